// File: doc/BRIEF.md
# Static Segment Display Refresh Sequencer

This block refreshes a chain of serial-in segment drivers that run a static, non-multiplexed display. Software or a neighbouring block presents a segment image on a parallel bus and pulses a load strobe while the ready flag is high. The sequencer then sends the image one bit per shift-clock pulse, highest segment first. After the last bit it issues a single latch pulse and raises ready again.

The sequencer also generates the alternating frame signal. This is a square wave with a 50% duty cycle that the drivers use to reverse the drive polarity. A latch pulse is held back until it can end exactly on a transition of that signal. As a result, a change of image never leaves an uneven share of the frame at one polarity. A parameter can reserve segment 1 as the drive for the common electrode. In that case the bit sent for it is always 0.

All timing is counted in system-clock cycles and set by parameters. At elaboration those parameters are checked against the nominal clock rate `SYS_HZ`. The checks cover: shift-clock phases of at least 450 ns and a shift rate of at most 1 MHz, at least 200 ns from the last shift fall to the latch fall, a latch high time of at least 450 ns, and a frame rate between 30 and 500 Hz.

Top module: `seg_refresh_seq`

## Requirements
- R1: While reset is applied, ready_o is 1 and sclk_o, sdata_o, latch_o and frame_o are all 0.
- R2: Each accepted load produces exactly NSEG shift-clock pulses. Each pulse is a rise followed by a fall, and the driver takes data at the fall. The bit present at the first fall is image_i[NSEG-1], and the bit at the last fall is image_i[0] (bit index k is segment k+1).
- R3: With COM_RESERVE set, the bit at the last fall (segment 1, image_i[0]) is 0 whatever the image. All other bits and all timing are identical to the setting without the reserve.
- R4: During a transfer, every high phase and every low phase between pulses of sclk_o lasts exactly SCLK_HALF cycles. sdata_o changes only in the cycle in which sclk_o rises, so it is stable across every fall.
- R5: Each transfer is followed by exactly one latch pulse, high for LATCH_HIGH cycles. It rises only after the last shift fall, and its fall comes at least GAP_CYC+LATCH_HIGH cycles after that shift fall.
- R6: The latch pulse falls in the same cycle as a transition of frame_o. This happens at the first suitable transition, and no later than FRAME_HALF+GAP_CYC+LATCH_HIGH+1 cycles after the last shift fall.
- R7: frame_o toggles exactly every FRAME_HALF cycles from reset, whether or not a transfer is in progress.
- R8: A load sampled while ready_o is 1 clears ready_o at the next edge. ready_o returns to 1 in the same cycle that the latch pulse falls. sclk_o and latch_o are low whenever ready_o is 1.
- R9: A load strobe while ready_o is 0 is ignored. The transfer in progress still sends the image captured when the load was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe; accepted only while ready_o is 1 |
| image_i | input | NSEG | Segment image; bit k drives segment k+1 |
| ready_o | output | 1 | High when a new image can be accepted |
| sclk_o | output | 1 | Shift clock to the driver chain; data taken on the fall |
| sdata_o | output | 1 | Serial data to the driver chain |
| latch_o | output | 1 | Latch clock; the driver updates on its fall |
| frame_o | output | 1 | Alternating frame signal, 50% duty |

## Verification
The bench starts loads at many different points of the frame period. A controller that latched as soon as shifting ended, or that missed the frame slot, would show a latch fall away from a frame transition or a wait longer than one half-period. Single-bit images at the top and bottom of the word show whether the order was reversed or whether the shifter dropped or repeated an end bit. A second instance with the reserved channel checks that only the final bit is cleared. The bench holds the strobe high while the block is busy; a design that restarted or reloaded the image on that strobe would send corrupted data.

// File: rtl/seg_refresh_pkg.sv
package seg_refresh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_WAIT  = 2'd2,
    ST_LATCH = 2'd3
  } seq_state_e;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/seg_frame_div.sv
module seg_frame_div #(
  parameter int FRAME_HALF = 20000,
  parameter int LATCH_HIGH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic frame_o,
  output logic edge_o,
  output logic slot_o
);

  localparam int FW = $clog2(FRAME_HALF + 1);

  logic [FW-1:0] fcnt_q, fcnt_d;
  logic          frame_q, frame_d;

  assign edge_o  = (fcnt_q == FW'(FRAME_HALF - 1));
  // the latch may start here so that it ends on the coming transition
  assign slot_o  = (fcnt_q == FW'(FRAME_HALF - 1 - LATCH_HIGH));
  assign frame_o = frame_q;

  always_comb begin
    if (edge_o) begin
      fcnt_d  = '0;
      frame_d = ~frame_q;
    end else begin
      fcnt_d  = fcnt_q + FW'(1);
      frame_d = frame_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q  <= '0;
      frame_q <= 1'b0;
    end else begin
      fcnt_q  <= fcnt_d;
      frame_q <= frame_d;
    end
  end

endmodule

// File: rtl/seg_shift_out.sv
module seg_shift_out #(
  parameter int NSEG        = 80,
  parameter int SCLK_HALF   = 2,
  parameter bit COM_RESERVE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NSEG-1:0] image_i,
  output logic            sclk_o,
  output logic            sdata_o,
  output logic            done_o
);

  localparam int BW = $clog2(NSEG);
  localparam int PW = $clog2(SCLK_HALF + 1);

  logic [NSEG-1:0] word;
  logic [NSEG-1:0] sreg_q, sreg_d;
  logic [BW-1:0]   bitcnt_q, bitcnt_d;
  logic [PW-1:0]   pcnt_q, pcnt_d;
  logic            sclk_q, sclk_d;
  logic            sdata_q, sdata_d;
  logic            busy_q, busy_d;
  logic            tick, last_bit, en;

  generate
    if (COM_RESERVE) begin : g_com
      assign word = {image_i[NSEG-1:1], 1'b0};
    end else begin : g_plain
      assign word = image_i;
    end
  endgenerate

  assign tick     = busy_q && (pcnt_q == PW'(SCLK_HALF - 1));
  assign last_bit = (bitcnt_q == BW'(NSEG - 1));
  assign done_o   = tick && sclk_q && last_bit;
  assign en       = start_i || busy_q;

  always_comb begin
    sreg_d   = sreg_q;
    bitcnt_d = bitcnt_q;
    pcnt_d   = pcnt_q;
    sclk_d   = sclk_q;
    sdata_d  = sdata_q;
    busy_d   = busy_q;
    if (start_i && !busy_q) begin
      busy_d   = 1'b1;
      sclk_d   = 1'b1;
      sdata_d  = word[NSEG-1];
      sreg_d   = word << 1;
      bitcnt_d = '0;
      pcnt_d   = '0;
    end else if (busy_q) begin
      if (tick) begin
        pcnt_d = '0;
        if (sclk_q) begin
          sclk_d = 1'b0;
          if (last_bit) busy_d = 1'b0;
        end else begin
          // new bit goes out together with the rising shift edge
          sclk_d   = 1'b1;
          sdata_d  = sreg_q[NSEG-1];
          sreg_d   = sreg_q << 1;
          bitcnt_d = bitcnt_q + BW'(1);
        end
      end else begin
        pcnt_d = pcnt_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q   <= '0;
      bitcnt_q <= '0;
      pcnt_q   <= '0;
      sclk_q   <= 1'b0;
      sdata_q  <= 1'b0;
      busy_q   <= 1'b0;
    end else if (en) begin
      sreg_q   <= sreg_d;
      bitcnt_q <= bitcnt_d;
      pcnt_q   <= pcnt_d;
      sclk_q   <= sclk_d;
      sdata_q  <= sdata_d;
      busy_q   <= busy_d;
    end
  end

  assign sclk_o  = sclk_q;
  assign sdata_o = sdata_q;

endmodule

// File: rtl/seg_latch_ctl.sv
module seg_latch_ctl
  import seg_refresh_pkg::*;
#(
  parameter int GAP_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic shift_done_i,
  input  logic slot_i,
  input  logic frame_edge_i,
  output logic start_o,
  output logic ready_o,
  output logic latch_o
);

  localparam int GW = $clog2(GAP_CYC + 2);

  seq_state_e    state_q, state_d;
  logic [GW-1:0] gcnt_q, gcnt_d;
  logic          latch_q, latch_d;
  logic          ready_q, ready_d;

  assign start_o = (state_q == ST_IDLE) && load_i;

  always_comb begin
    state_d = state_q;
    gcnt_d  = gcnt_q;
    latch_d = latch_q;
    ready_d = ready_q;
    case (state_q)
      ST_IDLE: begin
        if (load_i) begin
          state_d = ST_SHIFT;
          ready_d = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (shift_done_i) begin
          state_d = ST_WAIT;
          gcnt_d  = '0;
        end
      end
      ST_WAIT: begin
        if (gcnt_q == GW'(GAP_CYC)) begin
          if (slot_i) begin
            latch_d = 1'b1;
            state_d = ST_LATCH;
          end
        end else begin
          gcnt_d = gcnt_q + GW'(1);
        end
      end
      ST_LATCH: begin
        if (frame_edge_i) begin
          latch_d = 1'b0;
          ready_d = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gcnt_q  <= '0;
      latch_q <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      state_q <= state_d;
      gcnt_q  <= gcnt_d;
      latch_q <= latch_d;
      ready_q <= ready_d;
    end
  end

  assign ready_o = ready_q;
  assign latch_o = latch_q;

endmodule

// File: rtl/seg_refresh_seq.sv
module seg_refresh_seq #(
  parameter int NSEG        = 80,
  parameter int SYS_HZ      = 4_000_000,
  parameter int SCLK_HALF   = 2,
  parameter int GAP_CYC     = 1,
  parameter int LATCH_HIGH  = 2,
  parameter int FRAME_HALF  = 20000,
  parameter bit COM_RESERVE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [NSEG-1:0] image_i,
  output logic            ready_o,
  output logic            sclk_o,
  output logic            sdata_o,
  output logic            latch_o,
  output logic            frame_o
);

  localparam longint HZ = longint'(SYS_HZ);
  localparam longint NS = 64'd1_000_000_000;

  generate
    if (longint'(SCLK_HALF) * NS < 64'd450 * HZ) begin : g_err_phase
      $error("shift clock phase shorter than 450 ns");
    end
    if (HZ > longint'(2 * SCLK_HALF) * 64'd1_000_000) begin : g_err_rate
      $error("shift clock faster than 1 MHz");
    end
    if (longint'(GAP_CYC) * NS < 64'd200 * HZ) begin : g_err_gap
      $error("shift-to-latch gap shorter than 200 ns");
    end
    if (longint'(LATCH_HIGH) * NS < 64'd450 * HZ) begin : g_err_latch
      $error("latch pulse shorter than 450 ns");
    end
    if (HZ < 64'd60 * longint'(FRAME_HALF) || HZ > 64'd1000 * longint'(FRAME_HALF)) begin : g_err_frame
      $error("frame rate outside 30 to 500 Hz");
    end
    if (FRAME_HALF <= LATCH_HIGH + 1 || NSEG < 2) begin : g_err_shape
      $error("frame half period too short or segment count too small");
    end
  endgenerate

  logic rst_sync_n;
  logic start, shift_done, slot, frame_edge;

  seg_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  seg_frame_div #(
    .FRAME_HALF (FRAME_HALF),
    .LATCH_HIGH (LATCH_HIGH)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .frame_o (frame_o),
    .edge_o  (frame_edge),
    .slot_o  (slot)
  );

  seg_shift_out #(
    .NSEG        (NSEG),
    .SCLK_HALF   (SCLK_HALF),
    .COM_RESERVE (COM_RESERVE)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start),
    .image_i (image_i),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .done_o  (shift_done)
  );

  seg_latch_ctl #(
    .GAP_CYC (GAP_CYC)
  ) u_ctl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .load_i       (load_i),
    .shift_done_i (shift_done),
    .slot_i       (slot),
    .frame_edge_i (frame_edge),
    .start_o      (start),
    .ready_o      (ready_o),
    .latch_o      (latch_o)
  );

endmodule

// File: rtl/seg_refresh_seq_chk.sv
module seg_refresh_seq_chk #(
  parameter int FRAME_HALF = 20000
) (
  input logic clk,
  input logic rst_n,
  input logic ready_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic latch_o,
  input logic frame_o
);

  localparam int HW = $clog2(FRAME_HALF + 1);

  logic [HW-1:0] hcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              hcnt_q <= '0;
    else if (hcnt_q == HW'(FRAME_HALF - 1))  hcnt_q <= '0;
    else                                     hcnt_q <= hcnt_q + HW'(1);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!sclk_o && !latch_o)); // R8

  AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sclk_o) |-> $stable(sdata_o)); // R4

  AST_LATCH_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> !sclk_o); // R5

  AST_LATCH_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_o) |-> (frame_o != $past(frame_o))); // R6

  AST_READY_WITH_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $fell(latch_o)); // R8

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt_q != HW'(FRAME_HALF - 1)) |=> $stable(frame_o)); // R7

  AST_FRAME_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt_q == HW'(FRAME_HALF - 1)) |=> !$stable(frame_o)); // R7

endmodule

bind seg_refresh_seq seg_refresh_seq_chk #(
  .FRAME_HALF (FRAME_HALF)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .ready_o (ready_o),
  .sclk_o  (sclk_o),
  .sdata_o (sdata_o),
  .latch_o (latch_o),
  .frame_o (frame_o)
);

// File: tb/seg_refresh_seq_bench.sv
module seg_refresh_seq_bench;

  localparam int NSEG       = 80;
  localparam int SYS_HZ     = 250000;
  localparam int SCLK_HALF  = 2;
  localparam int GAP_CYC    = 3;
  localparam int LATCH_HIGH = 2;
  localparam int FRAME_HALF = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [NSEG-1:0] image = '0;
  logic ready_a, sclk_a, sdata_a, latch_a, frame_a;
  logic ready_b, sclk_b, sdata_b, latch_b, frame_b;

  always #2 clk = ~clk;

  seg_refresh_seq #(.NSEG(NSEG), .SYS_HZ(SYS_HZ), .SCLK_HALF(SCLK_HALF), .GAP_CYC(GAP_CYC),
    .LATCH_HIGH(LATCH_HIGH), .FRAME_HALF(FRAME_HALF), .COM_RESERVE(1'b0)) u_seg_refresh_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load), .image_i(image), .ready_o(ready_a),
    .sclk_o(sclk_a), .sdata_o(sdata_a), .latch_o(latch_a), .frame_o(frame_a));

  seg_refresh_seq #(.NSEG(NSEG), .SYS_HZ(SYS_HZ), .SCLK_HALF(SCLK_HALF), .GAP_CYC(GAP_CYC),
    .LATCH_HIGH(LATCH_HIGH), .FRAME_HALF(FRAME_HALF), .COM_RESERVE(1'b1)) u_seg_refresh_seq_com (
    .clk(clk), .rst_n(rst_n), .load_i(load), .image_i(image), .ready_o(ready_b),
    .sclk_o(sclk_b), .sdata_o(sdata_b), .latch_o(latch_b), .frame_o(frame_b));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NSEG-1:0] rnd_img();
    logic [95:0] w;
    w = {$urandom, $urandom, $urandom};
    return w[NSEG-1:0];
  endfunction

  function automatic logic [NSEG-1:0] com_img(logic [NSEG-1:0] img);
    return {img[NSEG-1:1], 1'b0};
  endfunction

  // monitor: owns all per-transfer statistics
  int cyc = 0;
  logic p_sclk, p_latch, p_frame, p_ready, p_sdata;
  int nbits, rise_c, fall_c, phase_bad, data_bad, nlatch, lrise_c, lwidth, lgap;
  int twin_bad, frame_bad, toggles, last_tog;
  bit lon_frame, rdy_with_latch;
  logic [NSEG-1:0] cap_a, cap_b;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_sclk = 0; p_latch = 0; p_frame = 0; p_ready = 1; p_sdata = 0;
      nbits = 0; rise_c = 0; fall_c = 0; phase_bad = 0; data_bad = 0;
      nlatch = 0; lrise_c = 0; lwidth = -1; lgap = -1; twin_bad = 0;
      frame_bad = 0; toggles = 0; last_tog = -1; lon_frame = 0; rdy_with_latch = 0;
      cap_a = '0; cap_b = '0;
    end else begin
      if (!ready_a && p_ready) begin
        nbits = 0; phase_bad = 0; nlatch = 0; lwidth = -1; lgap = -1;
        lon_frame = 0; rdy_with_latch = 0; cap_a = '0; cap_b = '0;
      end
      if (sclk_a && !p_sclk) begin
        if (nbits > 0 && cyc - fall_c != SCLK_HALF) phase_bad++;
        rise_c = cyc;
      end
      if (!sclk_a && p_sclk) begin
        if (cyc - rise_c != SCLK_HALF) phase_bad++;
        fall_c = cyc;
        nbits++;
        cap_a = {cap_a[NSEG-2:0], sdata_a};
        cap_b = {cap_b[NSEG-2:0], sdata_b};
      end
      if (sdata_a != p_sdata && !(sclk_a && !p_sclk)) data_bad++;
      if (latch_a && !p_latch) begin
        nlatch++;
        lrise_c = cyc;
      end
      if (!latch_a && p_latch) begin
        lwidth = cyc - lrise_c;
        lgap = cyc - fall_c;
        lon_frame = (frame_a != p_frame);
        rdy_with_latch = ready_a && !p_ready;
      end
      if (sclk_a != sclk_b || latch_a != latch_b || ready_a != ready_b || frame_a != frame_b)
        twin_bad++;
      if (frame_a != p_frame) begin
        if (last_tog >= 0 && cyc - last_tog != FRAME_HALF) frame_bad++;
        last_tog = cyc;
        toggles++;
      end
      p_sclk = sclk_a; p_latch = latch_a; p_frame = frame_a; p_ready = ready_a; p_sdata = sdata_a;
    end
  end

  task automatic run_update(logic [NSEG-1:0] img, int spam, int pre_idle);
    repeat (pre_idle) @(negedge clk);
    while (!ready_a) @(negedge clk);
    image = img;
    load = 1'b1;
    @(negedge clk);
    chk(ready_a == 1'b0, "R8", "ready drop after load", ready_a, 0);
    for (int i = 0; i < spam; i++) begin
      image = rnd_img();
      @(negedge clk);
    end
    load = 1'b0;
    image = rnd_img();
    while (!ready_a) @(negedge clk);
    @(negedge clk);
    chk(nbits == NSEG, "R2", "shift pulse count", nbits, NSEG);
    chk(cap_a == img, "R2", "shifted image order", cap_a, img);
    chk(cap_b == com_img(img), "R3", "reserved channel image", cap_b, com_img(img));
    chk(twin_bad == 0, "R3", "timing differs with reserve", twin_bad, 0);
    chk(phase_bad == 0 && data_bad == 0, "R4", "shift phases and data stability",
        phase_bad + data_bad, 0);
    chk(nlatch == 1 && lwidth == LATCH_HIGH, "R5", "latch count and width",
        {nlatch[15:0], lwidth[15:0]}, {16'd1, 16'(LATCH_HIGH)});
    chk(lgap >= GAP_CYC + LATCH_HIGH, "R5", "shift fall to latch fall", lgap, GAP_CYC + LATCH_HIGH);
    chk(lon_frame && lgap <= FRAME_HALF + GAP_CYC + LATCH_HIGH + 1, "R6",
        "latch fall on first frame edge", {lon_frame, lgap[30:0]},
        {1'b1, 31'(FRAME_HALF + GAP_CYC + LATCH_HIGH + 1)});
    chk(rdy_with_latch, "R8", "ready returns with latch fall", rdy_with_latch, 1);
    if (spam > 0) chk(cap_a == img, "R9", "load while busy ignored", cap_a, img);
  endtask

  initial begin
    int t0;
    logic [NSEG-1:0] pat;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    chk(ready_a && ready_b, "R1", "ready in reset", {ready_a, ready_b}, 2'b11);
    chk({sclk_a, sdata_a, latch_a, frame_a} == 4'b0, "R1", "outputs in reset",
        {sclk_a, sdata_a, latch_a, frame_a}, 0);
    chk({sclk_b, sdata_b, latch_b, frame_b} == 4'b0, "R1", "reserve outputs in reset",
        {sclk_b, sdata_b, latch_b, frame_b}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_update('0, 0, 0);
    run_update('1, 0, 5);
    for (int i = 0; i < NSEG; i++) pat[i] = i[0];
    run_update(pat, 0, 17);
    run_update(~pat, 0, FRAME_HALF - 3);
    pat = '0; pat[NSEG-1] = 1'b1;
    run_update(pat, 0, 1);
    pat = '0; pat[0] = 1'b1;
    run_update(pat, 0, 2);
    run_update(rnd_img(), 12, 0);

    t0 = toggles;
    repeat (3 * FRAME_HALF) @(negedge clk);
    chk(toggles - t0 == 3, "R7", "frame toggles while idle", toggles - t0, 3);
    chk(sclk_a == 1'b0 && latch_a == 1'b0, "R9", "no activity without load", {sclk_a, latch_a}, 0);

    for (int n = 0; n < 30; n++)
      run_update(rnd_img(), $urandom_range(0, 15), $urandom_range(0, 2 * FRAME_HALF));

    chk(frame_bad == 0 && toggles > 10, "R7", "frame half period", frame_bad, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog: actual=hung expected=ready");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule